// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA

This engine drains a software-built chain of transmit descriptors out of memory and turns each buffer into a byte stream for a downstream framer. A descriptor occupies three consecutive 32-bit words: the byte address of its buffer (+0), a control word (+4), and the byte address of the following descriptor (+8). Software fills the chain, writes the address of its first descriptor into the descriptor register, then sets the run bit. The engine reads each descriptor, streams its buffer, returns the descriptor by writing its control word back with the empty flag set, and moves on through the next pointer.

A frame may be split across several descriptors with the continuation flag. The engine halts cleanly when it reaches a descriptor that software still holds. It signals completed frames, starvation of the output mid-frame, and memory error responses as one-cycle events. It also keeps a wrapping count of the frames it has sent. Memory is reached through a simple request/acknowledge port that carries one word per access.

Top module: `tdma_tx`

## Requirements
- R1: After reset the run bit reads 0, no memory request or output byte is presented, no event is raised, and the frame count and descriptor register are 0.
- R2: With the run bit set and the engine idle, it reads the descriptor at the descriptor register: buffer address at +0, control word at +4, next pointer at +8. In the control word, bit 31 is the empty flag, bit 24 is the continuation flag and bits 11:0 are the byte count.
- R3: A descriptor whose empty flag is 1 clears the run bit. The engine then sends no byte, writes nothing back and leaves the descriptor register pointing at that descriptor. Setting the run bit again resumes from it.
- R4: For an owned descriptor the engine sends exactly byte-count bytes, starting at the buffer byte address, which may have any alignment. Byte k of a memory word sits in bits 8k+7:8k.
- R5: After the last byte of a descriptor, the engine writes its control word back to +4 with bit 31 set and all other bits unchanged. It then loads the descriptor register from the next pointer.
- R6: The last-byte marker is raised only on the final byte of a descriptor whose continuation flag is 0. A descriptor with byte count 0 sends nothing but is still returned.
- R7: Each returned descriptor with continuation flag 0 raises the frame-sent event for one cycle and increments the 8-bit frame count modulo 256.
- R8: Writing 0 to the run bit lets the descriptor in progress finish and be returned. No further descriptor is fetched.
- R9: If, inside a frame, the output has no byte available for more than the starvation limit of consecutive cycles, the engine raises the underrun event. It drops the frame, clears the run bit and does not return the descriptor.
- R10: An error response on any memory access raises the bus-error event and clears the run bit, and the engine goes idle.
- R11: While a byte is offered and the sink is not ready, the byte and its last marker stay unchanged. Sink backpressure never counts as starvation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Write strobe for the run bit |
| ctrlWrData | input | 1 | Value written to the run bit |
| descWr | input | 1 | Write strobe for the descriptor register |
| descWrAddr | input | ADDR_W | Descriptor address written |
| underrunLimit | input | LIMIT_W | Mid-frame starvation limit in cycles |
| running | output | 1 | Run bit readback |
| curDesc | output | ADDR_W | Current descriptor address |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Byte address of the word |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | One-cycle access completion |
| memErr | input | 1 | Error response, valid with memAck |
| memRdata | input | 32 | Read data, valid with memAck |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Final byte of the frame |
| outReady | input | 1 | Sink accepts the byte |
| evPktSent | output | 1 | Frame-sent event |
| evUnderrun | output | 1 | Underrun event |
| evBusErr | output | 1 | Memory error event |
| pktCount | output | COUNT_W | Frames sent, wrapping |

## Verification
The bench aims at frames split over unaligned buffers with a zero-length middle descriptor under sink backpressure. An engine that mishandles these would misplace the last marker, duplicate or skip bytes at word edges, or treat backpressure as starvation. It also stops on a still-held descriptor, both at the start and after a refill, where a wrong design would stream garbage or advance past it. It clears the run bit mid-descriptor, where a wrong design either cuts the transfer or keeps fetching. Finally it forces a slow memory to trigger underrun, injects an error response, and runs more than 256 frames. A wrong design there would return an abandoned descriptor, keep running after a fault, or fail to wrap the count.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int EMPTY_POS = 31;
  localparam int MORE_POS  = 24;
  localparam int SIZE_W    = 12;

  typedef enum logic [2:0] {
    S_IDLE, S_FBUF, S_FCTL, S_FNXT, S_MOVE, S_RET
  } phase_t;

  typedef struct packed {
    logic loadBuf;
    logic loadCtl;
    logic loadWord;
    logic abort;
  } dpStrobe_t;
endpackage

// File: rtl/tdma_datapath.sv
module tdma_datapath import tdma_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [31:0]        memRdata,
  input  logic [LIMIT_W-1:0] underrunLimit,
  input  logic               outReady,
  output logic               outValid,
  output logic [7:0]         outData,
  output logic               outLast,
  output logic [ADDR_W-1:0]  dataAddr,
  output logic               needWord,
  output logic               descDone,
  output logic               underrunHit
);
  logic [ADDR_W-1:0]  bufPtr;
  logic [SIZE_W-1:0]  remain;
  logic [31:0]        wordReg;
  logic               wordValid;
  logic               lastDesc;
  logic               midFrame;
  logic [LIMIT_W-1:0] stallCnt;
  logic               xfer;

  assign xfer = wordValid && outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufPtr    <= '0;
      remain    <= '0;
      wordReg   <= '0;
      wordValid <= 1'b0;
      lastDesc  <= 1'b0;
      midFrame  <= 1'b0;
      stallCnt  <= '0;
    end else begin
      if (stb.loadBuf) bufPtr <= memRdata[ADDR_W-1:0];
      if (stb.loadCtl) begin
        remain   <= memRdata[SIZE_W-1:0];
        lastDesc <= !memRdata[MORE_POS];
      end
      if (stb.loadWord) begin
        wordReg   <= memRdata;
        wordValid <= 1'b1;
      end
      if (xfer) begin
        bufPtr   <= bufPtr + ADDR_W'(1);
        remain   <= remain - SIZE_W'(1);
        midFrame <= !outLast;
        if (bufPtr[1:0] == 2'd3 || remain == SIZE_W'(1)) wordValid <= 1'b0;
      end
      if (stb.abort) begin
        wordValid <= 1'b0;
        midFrame  <= 1'b0;
      end
      if (!midFrame || wordValid) stallCnt <= '0;
      else if (stallCnt != '1)    stallCnt <= stallCnt + LIMIT_W'(1);
    end
  end

  assign outValid    = wordValid;
  assign outData     = wordReg[{bufPtr[1:0], 3'b000} +: 8];
  assign outLast     = lastDesc && (remain == SIZE_W'(1));
  assign dataAddr    = {bufPtr[ADDR_W-1:2], 2'b00};
  assign needWord    = !wordValid && (remain != '0);
  assign descDone    = !wordValid && (remain == '0);
  assign underrunHit = midFrame && !wordValid && (stallCnt >= underrunLimit);

  // R11: an offered byte waits unchanged for the sink
  a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R6: the last byte of a frame empties the stream before anything else
  a_r6_last_drains: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !outValid);
endmodule

// File: rtl/tdma_ctrl.sv
module tdma_ctrl import tdma_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWr,
  input  logic               ctrlWrData,
  input  logic               descWr,
  input  logic [ADDR_W-1:0]  descWrAddr,
  input  logic               memAck,
  input  logic               memErr,
  input  logic [31:0]        memRdata,
  input  logic               needWord,
  input  logic               descDone,
  input  logic               underrunHit,
  input  logic [ADDR_W-1:0]  dataAddr,
  output logic               running,
  output logic [ADDR_W-1:0]  curDesc,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [31:0]        memWdata,
  output dpStrobe_t          stb,
  output logic               evPktSent,
  output logic               evUnderrun,
  output logic               evBusErr,
  output logic [COUNT_W-1:0] pktCount
);
  phase_t            phase;
  logic              enable;
  logic [31:0]       ctlWord;
  logic [ADDR_W-1:0] nextPtr;
  logic              okAck, errAck, halt, emptySeen;

  always_comb begin
    memReq   = 1'b0;
    memWe    = 1'b0;
    memAddr  = curDesc;
    memWdata = ctlWord | (32'd1 << EMPTY_POS);
    unique case (phase)
      S_FBUF: memReq = 1'b1;
      S_FCTL: begin memReq = 1'b1; memAddr = curDesc + ADDR_W'(4); end
      S_FNXT: begin memReq = 1'b1; memAddr = curDesc + ADDR_W'(8); end
      S_MOVE: begin memReq = needWord; memAddr = dataAddr; end
      S_RET:  begin memReq = 1'b1; memWe = 1'b1; memAddr = curDesc + ADDR_W'(4); end
      default: ;
    endcase
    okAck     = memAck && memReq && !memErr;
    errAck    = memAck && memReq && memErr;
    halt      = errAck || (underrunHit && phase != S_IDLE);
    emptySeen = okAck && phase == S_FCTL && memRdata[EMPTY_POS];
    stb.abort    = halt || emptySeen;
    stb.loadBuf  = okAck && !halt && phase == S_FBUF;
    stb.loadCtl  = okAck && !halt && phase == S_FCTL && !memRdata[EMPTY_POS];
    stb.loadWord = okAck && !halt && phase == S_MOVE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= S_IDLE;
      enable     <= 1'b0;
      curDesc    <= '0;
      ctlWord    <= '0;
      nextPtr    <= '0;
      evPktSent  <= 1'b0;
      evUnderrun <= 1'b0;
      evBusErr   <= 1'b0;
      pktCount   <= '0;
    end else begin
      evPktSent  <= 1'b0;
      evUnderrun <= 1'b0;
      evBusErr   <= 1'b0;
      if (halt) begin
        phase      <= S_IDLE;
        enable     <= 1'b0;
        evBusErr   <= errAck;
        evUnderrun <= !errAck;
      end else begin
        unique case (phase)
          S_IDLE: if (enable) phase <= S_FBUF;
          S_FBUF: if (okAck) phase <= S_FCTL;
          S_FCTL: if (okAck) begin
            ctlWord <= memRdata;
            if (memRdata[EMPTY_POS]) begin
              enable <= 1'b0;
              phase  <= S_IDLE;
            end else begin
              phase  <= S_FNXT;
            end
          end
          S_FNXT: if (okAck) begin
            nextPtr <= memRdata[ADDR_W-1:0];
            phase   <= S_MOVE;
          end
          S_MOVE: if (descDone) phase <= S_RET;
          S_RET: if (okAck) begin
            curDesc <= nextPtr;
            if (!ctlWord[MORE_POS]) begin
              evPktSent <= 1'b1;
              pktCount  <= pktCount + COUNT_W'(1);
            end
            phase <= enable ? S_FBUF : S_IDLE;
          end
          default: phase <= S_IDLE;
        endcase
      end
      if (ctrlWr) enable  <= ctrlWrData;
      if (descWr) curDesc <= descWrAddr;
    end
  end

  assign running = enable;

  // R7: every frame-sent event advances the count by exactly one
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    evPktSent |-> (pktCount == $past(pktCount) + COUNT_W'(1)));

  // R9: an underrun leaves the engine stopped
  a_r9_underrun_stops: assert property (@(posedge clk) disable iff (!rstN)
    (evUnderrun && !$past(ctrlWr)) |-> !running);

  // R10: a memory error leaves the engine stopped
  a_r10_buserr_stops: assert property (@(posedge clk) disable iff (!rstN)
    (evBusErr && !$past(ctrlWr)) |-> !running);

  // R5: a write-back only ever targets the control word of the current descriptor
  a_r5_wb_target: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr == curDesc + ADDR_W'(4)));
endmodule

// File: rtl/tdma_tx.sv
module tdma_tx import tdma_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 8,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWr,
  input  logic               ctrlWrData,
  input  logic               descWr,
  input  logic [ADDR_W-1:0]  descWrAddr,
  input  logic [LIMIT_W-1:0] underrunLimit,
  output logic               running,
  output logic [ADDR_W-1:0]  curDesc,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [31:0]        memWdata,
  input  logic               memAck,
  input  logic               memErr,
  input  logic [31:0]        memRdata,
  output logic               outValid,
  output logic [7:0]         outData,
  output logic               outLast,
  input  logic               outReady,
  output logic               evPktSent,
  output logic               evUnderrun,
  output logic               evBusErr,
  output logic [COUNT_W-1:0] pktCount
);
  dpStrobe_t         stb;
  logic [ADDR_W-1:0] dataAddr;
  logic              needWord, descDone, underrunHit;

  tdma_ctrl #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .descWr(descWr), .descWrAddr(descWrAddr), .memAck(memAck), .memErr(memErr),
    .memRdata(memRdata), .needWord(needWord), .descDone(descDone),
    .underrunHit(underrunHit), .dataAddr(dataAddr), .running(running),
    .curDesc(curDesc), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .stb(stb), .evPktSent(evPktSent),
    .evUnderrun(evUnderrun), .evBusErr(evBusErr), .pktCount(pktCount)
  );

  tdma_datapath #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdata(memRdata),
    .underrunLimit(underrunLimit), .outReady(outReady), .outValid(outValid),
    .outData(outData), .outLast(outLast), .dataAddr(dataAddr),
    .needWord(needWord), .descDone(descDone), .underrunHit(underrunHit)
  );
endmodule

// File: tb/tb_tdma_tx.sv
`timescale 1ns/1ps
module tb_tdma_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWr = 1'b0, ctrlWrData = 1'b0, descWr = 1'b0;
  logic [31:0] descWrAddr = '0;
  logic [7:0]  underrunLimit = 8'd40;
  logic        running, memReq, memWe, memAck = 1'b0, memErr = 1'b0;
  logic [31:0] curDesc, memAddr, memWdata, memRdata = '0;
  logic        outValid, outLast, outReady = 1'b1;
  logic [7:0]  outData;
  logic        evPktSent, evUnderrun, evBusErr;
  logic [7:0]  pktCount;

  always #2 clk = ~clk;

  tdma_tx dut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .descWr(descWr), .descWrAddr(descWrAddr), .underrunLimit(underrunLimit),
    .running(running), .curDesc(curDesc), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memErr(memErr),
    .memRdata(memRdata), .outValid(outValid), .outData(outData),
    .outLast(outLast), .outReady(outReady), .evPktSent(evPktSent),
    .evUnderrun(evUnderrun), .evBusErr(evBusErr), .pktCount(pktCount)
  );

  // memory model, all writes happen here
  logic [31:0] mem [0:511];
  int          memLat = 0, errWord = -1, waitCnt = 0;
  logic        pokeEn = 1'b0;
  logic [31:0] pokeA = '0, pokeD = '0;

  always @(posedge clk) begin
    memAck <= 1'b0;
    memErr <= 1'b0;
    if (!rstN) begin
      for (int i = 0; i < 512; i++) mem[i] <= 32'hA5000000 ^ (i * 32'h01030507);
      waitCnt <= 0;
    end else begin
      if (pokeEn) mem[pokeA[10:2]] <= pokeD;
      if (memReq && !memAck) begin
        if (waitCnt >= memLat) begin
          waitCnt  <= 0;
          memAck   <= 1'b1;
          memRdata <= mem[memAddr[10:2]];
          if (int'(memAddr[10:2]) == errWord) memErr <= 1'b1;
          else if (memWe) mem[memAddr[10:2]] <= memWdata;
        end else waitCnt <= waitCnt + 1;
      end else waitCnt <= 0;
    end
  end

  int nChecks = 0, nFail = 0, nBytes = 0, nSent = 0, nUnder = 0, nBus = 0;
  int expPkts = 0;
  bit stallMode = 1'b0;
  int readyCnt = 0;
  logic [8:0] sbq[$];

  always @(posedge clk) begin
    #1;
    readyCnt++;
    outReady = stallMode ? ((readyCnt % 3) != 0) : 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (evPktSent) nSent++;
      if (evUnderrun) nUnder++;
      if (evBusErr) nBus++;
      if (outValid && outReady) begin
        nBytes++;
        nChecks++;
        if (sbq.size() == 0) begin
          nFail++;
          $display("FAIL R4 R6 unexpected byte: got %h expected none", {outLast, outData});
        end else begin
          automatic logic [8:0] e = sbq.pop_front();
          if ({outLast, outData} !== e) begin
            nFail++;
            $display("FAIL R4 R6 byte: got %h expected %h", {outLast, outData}, e);
          end
        end
      end
    end
  end

  task automatic poke(input int a, input logic [31:0] d);
    pokeA = a; pokeD = d; pokeEn = 1'b1;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  function automatic logic [31:0] ctlOf(bit empty, bit more, int ovr, int size);
    return {empty, 6'b0, more, 3'b0, ovr[4:0], 4'b0, size[11:0]};
  endfunction

  task automatic putDesc(input int a, input int bufA, input bit more, input int size,
                         input int ovr, input bit empty, input int nxt);
    poke(a, bufA);
    poke(a + 4, ctlOf(empty, more, ovr, size));
    poke(a + 8, nxt);
  endtask

  task automatic expectBytes(input int bufA, input int size, input bit lastDesc);
    for (int k = 0; k < size; k++) begin
      automatic int a = bufA + k;
      automatic logic [31:0] w = mem[a >> 2];
      sbq.push_back({lastDesc && (k == size - 1), w[8 * (a % 4) +: 8]});
    end
  endtask

  task automatic setDesc(input int a);
    @(negedge clk); descWr = 1'b1; descWrAddr = a;
    @(negedge clk); descWr = 1'b0;
  endtask

  task automatic setRun(input bit v);
    @(negedge clk); ctrlWr = 1'b1; ctrlWrData = v;
    @(negedge clk); ctrlWr = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (running && n < 4000) begin @(negedge clk); n++; end
    if (n >= 4000) chk("R8 engine never stopped", 32'd1, 32'd0);
    repeat (60) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [31:0] saved;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 running", running, 0);
    chk("R1 memReq", memReq, 0);
    chk("R1 outValid", outValid, 0);
    chk("R1 events", {evPktSent, evUnderrun, evBusErr}, 0);
    chk("R1 pktCount", pktCount, 0);
    chk("R1 curDesc", curDesc, 0);

    // R2 R4 R5 R7: single aligned frame, then held descriptor
    putDesc(32'h00, 32'h100, 0, 7, 5'h15, 0, 32'h0C);
    putDesc(32'h0C, 32'h0, 0, 0, 0, 1, 32'h0);
    setDesc(32'h00);
    expectBytes(32'h100, 7, 1);
    setRun(1);
    waitIdle();
    expPkts++;
    chk("R5 write-back word", mem[1], ctlOf(1, 0, 5'h15, 7));
    chk("R5 curDesc follows next", curDesc, 32'h0C);
    chk("R7 sent events", nSent, expPkts);
    chk("R7 pktCount", pktCount, expPkts);
    chk("R3 held desc untouched", mem[4], ctlOf(1, 0, 0, 0));
    chk("R4 all bytes sent", sbq.size(), 0);

    // R6 R11: unaligned, zero-length middle, backpressure
    putDesc(32'h20, 32'h183, 1, 5, 3, 0, 32'h2C);
    putDesc(32'h2C, 32'h1A0, 1, 0, 0, 0, 32'h38);
    putDesc(32'h38, 32'h1C1, 0, 6, 0, 0, 32'h44);
    putDesc(32'h44, 32'h202, 0, 9, 0, 0, 32'h50);
    putDesc(32'h50, 32'h0, 0, 0, 0, 1, 32'h0);
    expectBytes(32'h183, 5, 0);
    expectBytes(32'h1C1, 6, 1);
    expectBytes(32'h202, 9, 1);
    stallMode = 1'b1;
    setDesc(32'h20);
    setRun(1);
    waitIdle();
    stallMode = 1'b0;
    expPkts += 2;
    chk("R6 zero-length returned", mem[32'h30 >> 2], ctlOf(1, 1, 0, 0));
    chk("R11 no underrun under backpressure", nUnder, 0);
    chk("R7 pktCount multi", pktCount, expPkts);
    chk("R6 all bytes", sbq.size(), 0);
    chk("R5 curDesc at held", curDesc, 32'h50);

    // R3: start on a held descriptor
    saved = nBytes;
    setRun(1);
    waitIdle();
    chk("R3 run cleared", running, 0);
    chk("R3 no bytes", nBytes, saved);
    chk("R3 curDesc unchanged", curDesc, 32'h50);
    chk("R3 ctl unchanged", mem[32'h54 >> 2], ctlOf(1, 0, 0, 0));
    // R3: refill and resume from same place
    putDesc(32'h50, 32'h300, 0, 2, 0, 0, 32'hB4);
    putDesc(32'hB4, 32'h0, 0, 0, 0, 1, 32'h0);
    expectBytes(32'h300, 2, 1);
    setRun(1);
    waitIdle();
    expPkts++;
    chk("R3 resumed curDesc", curDesc, 32'hB4);
    chk("R3 resumed pktCount", pktCount, expPkts);

    // R8: stop request mid-descriptor
    putDesc(32'h60, 32'h240, 0, 6, 0, 0, 32'h6C);
    putDesc(32'h6C, 32'h250, 0, 3, 0, 0, 32'h78);
    putDesc(32'h78, 32'h0, 0, 0, 0, 1, 32'h0);
    expectBytes(32'h240, 6, 1);
    setDesc(32'h60);
    setRun(1);
    setRun(0);
    waitIdle();
    expPkts++;
    chk("R8 first returned", mem[32'h64 >> 2][31], 1);
    chk("R8 second not fetched", mem[32'h70 >> 2][31], 0);
    chk("R8 curDesc", curDesc, 32'h6C);
    chk("R8 pktCount", pktCount, expPkts);
    chk("R8 bytes", sbq.size(), 0);

    // R9: starvation mid-frame
    putDesc(32'h84, 32'h280, 0, 8, 0, 0, 32'h90);
    putDesc(32'h90, 32'h0, 0, 0, 0, 1, 32'h0);
    expectBytes(32'h280, 4, 0);
    memLat = 30;
    underrunLimit = 8'd10;
    setDesc(32'h84);
    setRun(1);
    waitIdle();
    memLat = 0;
    underrunLimit = 8'd40;
    chk("R9 underrun event", nUnder, 1);
    chk("R9 run cleared", running, 0);
    chk("R9 not returned", mem[32'h88 >> 2][31], 0);
    chk("R9 no frame counted", pktCount, expPkts);
    chk("R9 partial bytes", sbq.size(), 0);

    // R10: memory error on first data word
    putDesc(32'h9C, 32'h2C0, 0, 4, 0, 0, 32'hA8);
    errWord = 32'h2C0 >> 2;
    saved = nBytes;
    setDesc(32'h9C);
    setRun(1);
    waitIdle();
    errWord = -1;
    chk("R10 bus error event", nBus, 1);
    chk("R10 run cleared", running, 0);
    chk("R10 no bytes", nBytes, saved);
    chk("R10 not returned", mem[32'hA0 >> 2][31], 0);

    // R7: wrap of the 8-bit count
    for (int pass = 0; pass < 13; pass++) begin
      for (int d = 0; d < 20; d++)
        putDesc(32'h400 + 12 * d, 32'h500 + d, 0, 1, 0, 0, 32'h400 + 12 * (d + 1));
      putDesc(32'h400 + 12 * 20, 32'h0, 0, 0, 0, 1, 32'h0);
      for (int d = 0; d < 20; d++) expectBytes(32'h500 + d, 1, 1);
      setDesc(32'h400);
      setRun(1);
      waitIdle();
      expPkts += 20;
    end
    chk("R7 count wraps", pktCount, expPkts % 256);
    chk("R7 event total", nSent, expPkts);
    chk("R7 bytes", sbq.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule